// File: doc/BRIEF.md
# Transceiver Channel Manual Reset Sequencer

This block steps one serial transceiver channel through a reset in manual mode. The receive and transmit sides each have their own sequence. A start pulse for a direction raises that direction's slot request to an external reset scheduler. The direction's datapath resets are asserted only when the scheduler grants the slot and the analog front end reports ready. The resets are held for a minimum number of cycles and released under the same two conditions. The sequence then waits for the datapath to report that it can transfer data before it raises the direction's ready flag.

The transmit sequence drives one extra line, a reset for the whole forward-error-correction engine. It moves in step with the three transmit resets, inside the transmit grant window. If a grant is withdrawn before the resets are released, the resets stay asserted and the sequence asks for a new slot. A start pulse that arrives while a sequence is running is remembered and served once that sequence has finished. All pins are plain control and status levels. No stream interface exists, so there is no back-pressure.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, every reset output, both slot requests and both ready flags are low.
- R2: A start pulse on an idle or finished direction raises that direction's slot request in the next cycle. The request then stays high until the resets are released.
- R3: A direction's resets rise or fall only at a clock edge where that direction's grant and PMA-ready inputs are both high. While PMA-ready is low the resets keep their value.
- R4: With grant and PMA-ready held high, the resets stay high for exactly HOLD_CYC+1 cycles. They fall at the same edge where the slot request drops.
- R5: If the grant drops while the resets are high, the resets and the request stay high. After a new grant the full hold time starts again from zero.
- R6: The whole-FEC reset output equals the transmit resets in every cycle, so it is also changed only inside the transmit grant window.
- R7: The receive ready flag rises only after the receive transfer-ready input is high and CDR lock has been high for LOCK_CYC consecutive cycles. Any low cycle of lock restarts that count.
- R8: The transmit ready flag rises one cycle after transmit transfer-ready is seen high once the resets are released.
- R9: A ready flag stays high, with request and resets low, until a new start pulse. That pulse clears the flag in the next cycle.
- R10: A start pulse received while a sequence is running is kept. After the running sequence finishes, ready is high for one cycle and the request rises again.
- R11: The two directions are independent: a transmit sequence runs to completion while the receive sequence waits for its grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the sequencer |
| rx_start | input | 1 | Start pulse for a receive reset sequence |
| tx_start | input | 1 | Start pulse for a transmit reset sequence |
| rx_grant | input | 1 | Scheduler grant window for the receive side |
| tx_grant | input | 1 | Scheduler grant window for the transmit side |
| rx_pma_rdy | input | 1 | Receive analog front end ready |
| tx_pma_rdy | input | 1 | Transmit analog front end ready |
| rx_cdr_lock | input | 1 | Receiver clock recovery locked to data |
| rx_xfer_rdy | input | 1 | Receive interconnect datapath ready |
| tx_xfer_rdy | input | 1 | Transmit interconnect datapath ready |
| rx_slot_req | output | 1 | Receive reset slot request to the scheduler |
| tx_slot_req | output | 1 | Transmit reset slot request to the scheduler |
| rx_link_rst | output | 1 | Receive interconnect datapath reset |
| rx_pmadig_rst | output | 1 | Receive PMA digital logic reset |
| rx_fec_rst | output | 1 | Receive FEC datapath reset |
| tx_link_rst | output | 1 | Transmit interconnect datapath reset |
| tx_pmadig_rst | output | 1 | Transmit PMA digital logic reset |
| tx_fec_rst | output | 1 | Transmit FEC datapath reset |
| fec_all_rst | output | 1 | Reset of the whole FEC engine, moved with the transmit resets |
| rx_ready | output | 1 | Receive side out of reset and usable |
| tx_ready | output | 1 | Transmit side out of reset and usable |

## Verification
The bench builds the block with HOLD_CYC at 4 and LOCK_CYC at 6 in place of 8 and 16. Each complete sequence is then short enough that one run can cover a hold interrupted by a lost grant, a start that waits behind a running sequence, and several lock glitch patterns. With a lock window of six, a glitch before the window fills and a transfer-ready that arrives after the window has filled produce distinct ready latencies. These latencies can be checked exactly.

// File: rtl/xrs_pkg.sv
package xrs_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_REQ,
    S_WAIT_ACK,
    S_ASSERT,
    S_DEASSERT,
    S_WAIT_XFER,
    S_DONE
  } seq_state_e;
endpackage

// File: rtl/xrs_start_latch.sv
// Remembers a start pulse until the direction sequencer accepts it.
module xrs_start_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic take_i,
  output logic pend_o
);
  logic pend_q;

  assign pend_o = start_i | pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_o & ~take_i;
  end
endmodule

// File: rtl/xrs_hold_timer.sv
// Counts reset hold cycles; restarts on clear, saturates at the limit.
module xrs_hold_timer #(
  parameter int HOLD_CYC = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic en_i,
  output logic done_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear_i)          cnt_q <= '0;
    else if (en_i && !done_o)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xrs_lock_filter.sv
// Reports lock as stable once it has been high LOCK_CYC cycles in a row.
module xrs_lock_filter #(
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  output logic stable_o
);
  localparam int LW = $clog2(LOCK_CYC + 1);
  localparam logic [LW-1:0] FULL = LW'(LOCK_CYC);

  logic [LW-1:0] run_q;

  assign stable_o = (run_q == FULL);

  always_ff @(posedge clk) begin
    if (!rst_n)         run_q <= '0;
    else if (!lock_i)   run_q <= '0;
    else if (!stable_o) run_q <= run_q + 1'b1;
  end
endmodule

// File: rtl/xrs_dir_seq.sv
// One direction: request a slot, pulse the resets inside it, wait for datapath.
module xrs_dir_seq
  import xrs_pkg::*;
#(
  parameter int NRST     = 3,
  parameter int HOLD_CYC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            ack_i,
  input  logic            pma_rdy_i,
  input  logic            xfer_ok_i,
  output logic            req_o,
  output logic [NRST-1:0] rst_o,
  output logic            ready_o
);
  seq_state_e state_q, state_d;
  logic       rst_q, rst_d;
  logic       pend, take, tmr_clr, tmr_en, tmr_done;

  xrs_start_latch u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .take_i  (take),
    .pend_o  (pend)
  );

  xrs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (tmr_clr),
    .en_i    (tmr_en),
    .done_o  (tmr_done)
  );

  assign tmr_en = (state_q == S_ASSERT) && ack_i;

  always_comb begin
    state_d = state_q;
    rst_d   = rst_q;
    take    = 1'b0;
    tmr_clr = 1'b0;
    unique case (state_q)
      S_IDLE, S_DONE: begin
        if (pend) begin
          take    = 1'b1;
          state_d = S_REQ;
        end
      end
      S_REQ: state_d = S_WAIT_ACK;
      S_WAIT_ACK: begin
        if (ack_i && pma_rdy_i) begin
          rst_d   = 1'b1;
          tmr_clr = 1'b1;
          state_d = S_ASSERT;
        end
      end
      S_ASSERT: begin
        if (!ack_i)        state_d = S_REQ;
        else if (tmr_done) state_d = S_DEASSERT;
      end
      S_DEASSERT: begin
        if (!ack_i) state_d = S_REQ;
        else if (pma_rdy_i) begin
          rst_d   = 1'b0;
          state_d = S_WAIT_XFER;
        end
      end
      S_WAIT_XFER: begin
        if (xfer_ok_i) state_d = S_DONE;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      rst_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rst_q   <= rst_d;
    end
  end

  assign req_o   = (state_q == S_REQ) || (state_q == S_WAIT_ACK) ||
                   (state_q == S_ASSERT) || (state_q == S_DEASSERT);
  assign ready_o = (state_q == S_DONE);

  for (genvar g = 0; g < NRST; g++) begin : g_rst
    assign rst_o[g] = rst_q;
  end
endmodule

// File: rtl/xcvr_rst_seq.sv
module xcvr_rst_seq #(
  parameter int HOLD_CYC = 8,
  parameter int LOCK_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_start,
  input  logic tx_start,
  input  logic rx_grant,
  input  logic tx_grant,
  input  logic rx_pma_rdy,
  input  logic tx_pma_rdy,
  input  logic rx_cdr_lock,
  input  logic rx_xfer_rdy,
  input  logic tx_xfer_rdy,
  output logic rx_slot_req,
  output logic tx_slot_req,
  output logic rx_link_rst,
  output logic rx_pmadig_rst,
  output logic rx_fec_rst,
  output logic tx_link_rst,
  output logic tx_pmadig_rst,
  output logic tx_fec_rst,
  output logic fec_all_rst,
  output logic rx_ready,
  output logic tx_ready
);
  localparam int RX_NRST = 3;
  localparam int TX_NRST = RX_NRST + 1;

  logic [RX_NRST-1:0] rx_rst;
  logic [TX_NRST-1:0] tx_rst;
  logic               lock_ok;

  xrs_lock_filter #(.LOCK_CYC(LOCK_CYC)) u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .lock_i   (rx_cdr_lock),
    .stable_o (lock_ok)
  );

  xrs_dir_seq #(.NRST(RX_NRST), .HOLD_CYC(HOLD_CYC)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (rx_start),
    .ack_i     (rx_grant),
    .pma_rdy_i (rx_pma_rdy),
    .xfer_ok_i (rx_xfer_rdy & lock_ok),
    .req_o     (rx_slot_req),
    .rst_o     (rx_rst),
    .ready_o   (rx_ready)
  );

  xrs_dir_seq #(.NRST(TX_NRST), .HOLD_CYC(HOLD_CYC)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (tx_start),
    .ack_i     (tx_grant),
    .pma_rdy_i (tx_pma_rdy),
    .xfer_ok_i (tx_xfer_rdy),
    .req_o     (tx_slot_req),
    .rst_o     (tx_rst),
    .ready_o   (tx_ready)
  );

  assign rx_link_rst   = rx_rst[0];
  assign rx_pmadig_rst = rx_rst[1];
  assign rx_fec_rst    = rx_rst[2];
  assign tx_link_rst   = tx_rst[0];
  assign tx_pmadig_rst = tx_rst[1];
  assign tx_fec_rst    = tx_rst[2];
  assign fec_all_rst   = tx_rst[3];
endmodule

// File: rtl/xrs_checker.sv
module xrs_checker (
  input logic clk,
  input logic rst_n,
  input logic rx_grant,
  input logic tx_grant,
  input logic rx_pma_rdy,
  input logic tx_pma_rdy,
  input logic rx_cdr_lock,
  input logic rx_xfer_rdy,
  input logic tx_xfer_rdy,
  input logic rx_slot_req,
  input logic tx_slot_req,
  input logic rx_link_rst,
  input logic rx_pmadig_rst,
  input logic rx_fec_rst,
  input logic tx_link_rst,
  input logic tx_pmadig_rst,
  input logic tx_fec_rst,
  input logic fec_all_rst,
  input logic rx_ready,
  input logic tx_ready
);
  p_rx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({rx_link_rst, rx_pmadig_rst, rx_fec_rst}) |-> $past(rx_grant && rx_pma_rdy));

  p_tx_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({tx_link_rst, tx_pmadig_rst, tx_fec_rst}) |-> $past(tx_grant && tx_pma_rdy));

  p_fec_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fec_all_rst) |-> $past(tx_grant && tx_pma_rdy));

  p_rx_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_link_rst) |-> !rx_slot_req);

  p_tx_req_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_link_rst) |-> !tx_slot_req);

  p_rx_abort_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_link_rst && !rx_grant) |=> rx_link_rst);

  p_tx_abort_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_link_rst && !tx_grant) |=> tx_link_rst);

  p_rx_ready_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> $past(rx_xfer_rdy && rx_cdr_lock));

  p_tx_ready_xfer_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ready) |-> $past(tx_xfer_rdy));

  p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ready |-> !tx_slot_req && !tx_link_rst) and
    (rx_ready |-> !rx_slot_req && !rx_link_rst));
endmodule

bind xcvr_rst_seq xrs_checker chk_i (.*);

// File: tb/xcvr_rst_seq_tb.sv
module xcvr_rst_seq_tb_top;
  localparam int HOLD = 4;
  localparam int LOCK = 6;
  localparam int NVEC = 4;
  // pre-glitch lock cycles, transfer-ready delay, expected ready latency (R7)
  localparam int VEC [NVEC][3] = '{'{0, 0, 7}, '{3, 0, 7}, '{0, 10, 11}, '{5, 2, 7}};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_start = 0, tx_start = 0, rx_grant = 0, tx_grant = 0;
  logic rx_pma_rdy = 0, tx_pma_rdy = 0, rx_cdr_lock = 0, rx_xfer_rdy = 0, tx_xfer_rdy = 0;
  logic rx_slot_req, tx_slot_req, rx_link_rst, rx_pmadig_rst, rx_fec_rst;
  logic tx_link_rst, tx_pmadig_rst, tx_fec_rst, fec_all_rst, rx_ready, tx_ready;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xcvr_rst_seq #(.HOLD_CYC(HOLD), .LOCK_CYC(LOCK)) dut_i (.*);

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Waits for a full assert/release of one direction's resets.
  task automatic rst_cycle(input bit is_tx);
    bit seen = 0;
    for (int k = 0; k < 60; k++) begin
      tick();
      if (is_tx ? tx_link_rst : rx_link_rst) seen = 1;
      else if (seen) break;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int hi;
    int lat;
    int bad;
    repeat (3) tick();
    chk("R1 outputs in reset", int'({rx_slot_req, tx_slot_req, rx_link_rst, tx_link_rst,
        fec_all_rst, rx_ready, tx_ready}), 0);
    rst_n = 1'b1;
    tick();
    chk("R1 outputs after reset", int'({rx_slot_req, tx_slot_req, rx_link_rst, tx_link_rst,
        fec_all_rst, rx_ready, tx_ready}), 0);

    // TX full sequence with PMA gating
    tx_start = 1; tick(); tx_start = 0;
    chk("R2 tx request", tx_slot_req, 1);
    tx_grant = 1;
    for (int k = 0; k < 5; k++) begin
      tick();
      chk("R3 no reset without pma", tx_link_rst, 0);
    end
    tx_pma_rdy = 1;
    hi = 0;
    bad = 0;
    for (int k = 0; k < 20; k++) begin
      tick();
      if (fec_all_rst != tx_link_rst || tx_fec_rst != tx_link_rst) bad++;
      if (tx_link_rst) hi++;
      else break;
    end
    chk("R4 hold length", hi, HOLD + 1);
    chk("R4 request drops with release", tx_slot_req, 0);
    chk("R6 fec-wide reset tracks tx", bad, 0);
    tx_grant = 0;
    tick();
    chk("R8 no ready before xfer", tx_ready, 0);
    tx_xfer_rdy = 1;
    tick();
    chk("R8 tx ready", tx_ready, 1);
    repeat (3) tick();
    chk("R9 ready held", int'({tx_ready, tx_slot_req, tx_link_rst}), 4);
    tx_xfer_rdy = 0;
    tx_start = 1; tick(); tx_start = 0;
    chk("R9 restart clears ready", tx_ready, 0);
    chk("R2 restart request", tx_slot_req, 1);

    // Grant withdrawn mid-hold
    tx_grant = 1;
    for (int k = 0; k < 10; k++) begin
      tick();
      if (tx_link_rst) break;
    end
    tick(); tick();
    tx_grant = 0;
    bad = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (!tx_link_rst || !tx_slot_req) bad++;
    end
    chk("R5 resets and request kept", bad, 0);
    tx_grant = 1;
    bad = 0;
    for (int k = 0; k < HOLD + 1; k++) begin
      tick();
      if (!tx_link_rst) bad++;
    end
    chk("R5 hold restarts", bad, 0);
    tick();
    chk("R5 release after new hold", tx_link_rst, 0);
    tx_grant = 0;
    tx_xfer_rdy = 1;
    tick();
    chk("R8 ready after abort run", tx_ready, 1);

    // Start latched during a running sequence
    tx_xfer_rdy = 0;
    tx_start = 1; tick(); tx_start = 0;
    tick();
    tx_start = 1; tick(); tx_start = 0;
    tx_grant = 1;
    tx_xfer_rdy = 1;
    rst_cycle(1'b1);
    tick();
    chk("R10 ready after first run", tx_ready, 1);
    tick();
    chk("R10 pending start served", int'({tx_ready, tx_slot_req}), 1);
    for (int k = 0; k < 40; k++) begin
      tick();
      if (tx_ready) break;
    end
    tx_grant = 0;
    tick();
    chk("R10 only one pending", tx_ready, 1);
    tx_xfer_rdy = 0;

    // Independence
    rx_pma_rdy = 1;
    rx_start = 1; tick(); rx_start = 0;
    tx_start = 1; tick(); tx_start = 0;
    tx_grant = 1;
    tx_xfer_rdy = 1;
    bad = 0;
    for (int k = 0; k < 40; k++) begin
      tick();
      if (rx_link_rst || !rx_slot_req) bad++;
      if (tx_ready) break;
    end
    chk("R11 tx completes", tx_ready, 1);
    chk("R11 rx untouched", bad, 0);
    tx_grant = 0;
    tx_xfer_rdy = 0;

    // Lock filter table
    for (int i = 0; i < NVEC; i++) begin
      rx_cdr_lock = 0;
      rx_xfer_rdy = 0;
      if (i > 0) begin
        rx_start = 1; tick(); rx_start = 0;
      end
      rx_grant = 1;
      rst_cycle(1'b0);
      rx_grant = 0;
      if (VEC[i][0] > 0) begin
        rx_cdr_lock = 1;
        repeat (VEC[i][0]) tick();
        rx_cdr_lock = 0;
        tick();
        chk("R7 no ready on short lock", rx_ready, 0);
      end
      rx_cdr_lock = 1;
      rx_xfer_rdy = (VEC[i][1] == 0);
      lat = -1;
      for (int k = 1; k < 40; k++) begin
        tick();
        if (rx_ready) begin
          lat = k;
          break;
        end
        if (k == VEC[i][1]) rx_xfer_rdy = 1;
      end
      chk("R7 rx ready latency", lat, VEC[i][2]);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule